// File: doc/BRIEF.md
# Clock Stop Gate and Output Clock Selector

This block sits between a processor's clock source and its core. It produces the core's clock enable and lets that enable be halted cleanly, either from an active-low external stop pin or from a stop bit in a power-control register. A halt takes effect only on a clock-enable boundary after a two-flop synchronizer. Releasing the stop lets the core continue from where it paused, and no state is lost. All clocks are modelled as single-cycle enable strobes on one fast clock, and the clock-out pin is a toggle flop driven by the selected strobe.

The same block drives a clock-out pin. A 3-bit select field picks one of several sources: the core's own clock, the instruction-cycle wait-stated clock, the memory-sequencer wait-stated clock, the reference input clock, or a constant level. A slow-clock mode replaces the first three sources with the ring-oscillator strobe. A change of select is applied only while the clock-out is low, so the pin never shows a runt pulse.

Top module: `clkStopOut`

## Requirements
- R1: Once the stop pin goes low, the core enable keeps following the base tick for two synchronizer cycles. The halt is then latched at the next base tick, and no core enable pulse appears while the stop stays asserted.
- R2: Once the stop pin returns high, the halt clears at the first base tick after two synchronizer cycles. Core enable pulses then resume on every base tick.
- R3: Setting the stop bit has the same effect and the same latency as driving the stop pin low. Clearing the bit has the same effect as releasing the pin.
- R4: The halt state changes only on a cycle that carries a base tick. The base tick is the main tick, or the ring tick when slow mode is on.
- R5: Select code 0 toggles clock-out on every main tick. The core stop has no effect on it.
- R6: Select code 1 toggles clock-out on every instruction-cycle tick.
- R7: Select code 2 toggles clock-out on every sequencer tick.
- R8: When slow mode is on, codes 0, 1 and 2 toggle on the ring tick instead, and the core enable follows the ring tick.
- R9: Select code 3 toggles clock-out on every reference tick, whatever the slow mode or stop state.
- R10: Codes 4, 6 and 7 hold clock-out at 0. Code 5 holds it at 1. Strobes on any source have no effect in these codes.
- R11: A new select code takes effect only while clock-out is low. While clock-out is high, the old source keeps driving it. When leaving code 5, clock-out is first driven low.
- R12: After reset, clock-out is 0, the core is not halted and code 0 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock on which all strobes are sampled |
| rstN | input | 1 | Active-low synchronous reset |
| mainTick | input | 1 | Internal processor clock strobe |
| ringTick | input | 1 | Ring-oscillator clock strobe |
| slowMode | input | 1 | Substitute the ring strobe for the processor-rate sources |
| instrTick | input | 1 | Wait-stated instruction-cycle strobe |
| seqTick | input | 1 | Wait-stated memory-sequencer strobe |
| refTick | input | 1 | Reference input clock strobe |
| stopPinN | input | 1 | Active-low stop pin, asynchronous to the block |
| stopBit | input | 1 | Software stop bit from the power-control register |
| outSel | input | 3 | Clock-out source select code |
| coreEn | output | 1 | Gated core clock enable |
| clkOut | output | 1 | Clock-out pin level |

## Verification
Some rules hold on every cycle, and the assertions check these. The halt holds while the stop stays asserted and stays clear while it is released. The halt changes only on a base tick. A select change never happens while clock-out is high. The constant codes really do hold their level. Other properties can only be shown by the bench scenarios, which count clock-out toggles and core enable pulses over windows of known strobe patterns. These are the exact stop and restart latency, how each source is picked, ring-tick substitution, immunity of the reference source, and a clock-out held high across a pending select change.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int SEL_W      = 3;
  localparam int SRC_COUNT  = 4;
  localparam int SRC_IDX_W  = $clog2(SRC_COUNT);

  localparam logic [SEL_W-1:0] SEL_CORE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_INSTR = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SEQ   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_REF   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_LOW   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_HIGH  = 3'd5;

  typedef struct packed {
    logic run;
    logic toggle;
    logic forceLow;
    logic forceHigh;
  } outStrobe_t;
endpackage

// File: rtl/clkStopSync.sv
module clkStopSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gOne
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : gMany
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkOutPath.sv
module clkOutPath
  import clk_stop_pkg::*;
#(
  parameter int SLOW_SRCS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mainTick,
  input  logic                 ringTick,
  input  logic                 slowMode,
  input  logic                 instrTick,
  input  logic                 seqTick,
  input  logic                 refTick,
  input  outStrobe_t           strobe,
  output logic [SRC_COUNT-1:0] srcTick,
  output logic                 baseTick,
  output logic                 coreEn,
  output logic                 clkOut
);
  logic [SRC_COUNT-1:0] rawTick;
  assign rawTick = {refTick, seqTick, instrTick, mainTick};

  // Sources below SLOW_SRCS fall back to the ring strobe in slow mode.
  generate
    for (genvar g = 0; g < SRC_COUNT; g++) begin : gSrc
      if (g < SLOW_SRCS) begin : gSlow
        assign srcTick[g] = slowMode ? ringTick : rawTick[g];
      end else begin : gFixed
        assign srcTick[g] = rawTick[g];
      end
    end
  endgenerate

  assign baseTick = srcTick[0];
  assign coreEn   = baseTick & strobe.run;

  always_ff @(posedge clk) begin
    if (!rstN)                 clkOut <= 1'b0;
    else if (strobe.forceHigh) clkOut <= 1'b1;
    else if (strobe.forceLow)  clkOut <= 1'b0;
    else if (strobe.toggle)    clkOut <= ~clkOut;
  end
endmodule

// File: rtl/clkStopCtrl.sv
module clkStopCtrl
  import clk_stop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stopPinN,
  input  logic                 stopBit,
  input  logic [SEL_W-1:0]     outSel,
  input  logic [SRC_COUNT-1:0] srcTick,
  input  logic                 baseTick,
  input  logic                 clkOut,
  output outStrobe_t           strobe
);
  logic stopRaw;
  logic stopSync;
  logic halted;
  logic [SEL_W-1:0] activeSel;
  logic pending;
  logic switchNow;

  assign stopRaw = ~stopPinN | stopBit;

  clkStopSync #(.STAGES(SYNC_STAGES)) u_stopSync (
    .clk  (clk),
    .rstN (rstN),
    .d    (stopRaw),
    .q    (stopSync)
  );

  // The halt is latched only on a base tick, so no partial core cycle.
  always_ff @(posedge clk) begin
    if (!rstN)         halted <= 1'b0;
    else if (baseTick) halted <= stopSync;
  end

  assign pending   = (outSel != activeSel);
  assign switchNow = pending & ~clkOut;

  always_ff @(posedge clk) begin
    if (!rstN)          activeSel <= SEL_CORE;
    else if (switchNow) activeSel <= outSel;
  end

  always_comb begin
    strobe           = '0;
    strobe.run       = ~halted;
    if (switchNow) begin
      strobe.forceLow = 1'b1;
    end else begin
      case (activeSel)
        SEL_CORE, SEL_INSTR, SEL_SEQ, SEL_REF:
          strobe.toggle = srcTick[activeSel[SRC_IDX_W-1:0]];
        SEL_HIGH: begin
          if (pending) strobe.forceLow  = 1'b1;
          else         strobe.forceHigh = 1'b1;
        end
        default:
          strobe.forceLow = 1'b1;
      endcase
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (halted && stopSync) |=> halted); // R1
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !stopSync) |=> !halted); // R2
  AST_HALT_AT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(halted) |-> $past(baseTick)); // R4
  AST_SEL_SWITCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (activeSel != $past(activeSel)) |-> !$past(clkOut)); // R11
  AST_CONST_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(activeSel == SEL_LOW || activeSel > SEL_HIGH) |-> !clkOut); // R10
  AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $past(activeSel == SEL_HIGH && outSel == SEL_HIGH) |-> clkOut); // R10
endmodule

// File: rtl/clkStopOut.sv
module clkStopOut
  import clk_stop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_SRCS   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mainTick,
  input  logic             ringTick,
  input  logic             slowMode,
  input  logic             instrTick,
  input  logic             seqTick,
  input  logic             refTick,
  input  logic             stopPinN,
  input  logic             stopBit,
  input  logic [SEL_W-1:0] outSel,
  output logic             coreEn,
  output logic             clkOut
);
  outStrobe_t           strobe;
  logic [SRC_COUNT-1:0] srcTick;
  logic                 baseTick;

  clkStopCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stopPinN (stopPinN),
    .stopBit  (stopBit),
    .outSel   (outSel),
    .srcTick  (srcTick),
    .baseTick (baseTick),
    .clkOut   (clkOut),
    .strobe   (strobe)
  );

  clkOutPath #(.SLOW_SRCS(SLOW_SRCS)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .mainTick  (mainTick),
    .ringTick  (ringTick),
    .slowMode  (slowMode),
    .instrTick (instrTick),
    .seqTick   (seqTick),
    .refTick   (refTick),
    .strobe    (strobe),
    .srcTick   (srcTick),
    .baseTick  (baseTick),
    .coreEn    (coreEn),
    .clkOut    (clkOut)
  );
endmodule

// File: tb/clkStopOut_tb.sv
module clkStopOut_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mainTick = 0, ringTick = 0, slowMode = 0, instrTick = 0, seqTick = 0, refTick = 0;
  logic stopPinN = 1'b1, stopBit = 1'b0;
  logic [2:0] outSel = 3'd0;
  logic coreEn, clkOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkStopOut u_dut (
    .clk(clk), .rstN(rstN), .mainTick(mainTick), .ringTick(ringTick),
    .slowMode(slowMode), .instrTick(instrTick), .seqTick(seqTick),
    .refTick(refTick), .stopPinN(stopPinN), .stopBit(stopBit),
    .outSel(outSel), .coreEn(coreEn), .clkOut(clkOut)
  );

  typedef struct {
    string tag;
    int    expToggles;
    int    expCore;
    int    expLevel;
  } expItem_t;

  expItem_t expQ[$];
  int   toggleCnt = 0, coreCnt = 0, checks = 0, fails = 0;
  int   t0 = 0, c0 = 0;
  logic prevOut = 1'b0;
  event winStart, winEnd;

  // Monitor: counts output activity away from the active edge.
  always @(negedge clk) begin
    if (clkOut !== prevOut) toggleCnt++;
    prevOut = clkOut;
    if (coreEn === 1'b1) coreCnt++;
  end

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard: pops the expected item at the end of each window.
  initial forever begin
    @(winStart);
    t0 = toggleCnt;
    c0 = coreCnt;
    @(winEnd);
    if (expQ.size() == 0) begin
      cmp("queue", "empty", 0, 1);
    end else begin
      expItem_t it;
      it = expQ.pop_front();
      if (it.expToggles >= 0) cmp(it.tag, "toggles", toggleCnt - t0, it.expToggles);
      if (it.expCore >= 0)    cmp(it.tag, "coreEn pulses", coreCnt - c0, it.expCore);
      if (it.expLevel >= 0)   cmp(it.tag, "clkOut level", int'(clkOut), it.expLevel);
    end
  end

  function automatic logic tk(int per, int i);
    return (per > 0) && (i % per == 0);
  endfunction

  task automatic idle(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // Driver: runs a strobe pattern and pushes the expected result.
  task automatic runWindow(string tag, int n, int pm, int pr, int pi, int ps, int pf,
                           logic pinN, logic bitV, int expT, int expC, int expL);
    @(posedge clk); #1;
    ->winStart;
    stopPinN = pinN;
    stopBit  = bitV;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      mainTick = tk(pm, i); ringTick = tk(pr, i); instrTick = tk(pi, i);
      seqTick = tk(ps, i); refTick = tk(pf, i);
    end
    @(posedge clk); #1;
    {mainTick, ringTick, instrTick, seqTick, refTick} = '0;
    idle(2);
    expQ.push_back('{tag, expT, expC, expL});
    ->winEnd;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(2);
    runWindow("R12 reset", 4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    runWindow("R5 core clock", 20, 1, 0, 0, 0, 0, 1, 0, 20, 20, 0);
    runWindow("R1 stop latency R5", 20, 1, 0, 0, 0, 0, 0, 0, 20, 3, 0);
    runWindow("R1 stop held", 20, 1, 0, 0, 0, 0, 0, 0, 20, 0, 0);
    runWindow("R2 restart", 20, 1, 0, 0, 0, 0, 1, 0, 20, 17, 0);
    runWindow("R3 bit stop", 20, 1, 0, 0, 0, 0, 1, 1, 20, 3, 0);
    runWindow("R3 bit release", 20, 1, 0, 0, 0, 0, 1, 0, 20, 17, 0);
    runWindow("R4 sparse stop", 24, 4, 0, 0, 0, 0, 0, 0, 6, 2, 0);
    runWindow("R4 sparse release", 24, 4, 0, 0, 0, 0, 1, 0, 6, 4, 0);
    outSel = 3'd1; idle(3);
    runWindow("R6 instr", 18, 1, 0, 3, 2, 1, 1, 0, 6, 18, 0);
    outSel = 3'd2; idle(3);
    runWindow("R7 seq", 16, 1, 0, 1, 4, 1, 1, 0, 4, 16, 0);
    outSel = 3'd0; slowMode = 1'b1; idle(3);
    runWindow("R8 slow core", 20, 1, 5, 1, 1, 0, 1, 0, 4, 4, 0);
    outSel = 3'd1; idle(3);
    runWindow("R8 slow instr", 20, 1, 5, 1, 1, 0, 1, 0, 4, 4, 0);
    outSel = 3'd3; idle(3);
    runWindow("R9 ref slow stop", 20, 1, 5, 1, 1, 2, 0, 0, 10, 2, 0);
    slowMode = 1'b0; idle(3);
    runWindow("R2 restart ref", 20, 1, 0, 0, 0, 0, 1, 0, 0, 17, 0);
    outSel = 3'd4; idle(3);
    runWindow("R10 code4", 10, 1, 1, 1, 1, 1, 1, 0, 0, 10, 0);
    outSel = 3'd6; idle(3);
    runWindow("R10 code6", 10, 1, 1, 1, 1, 1, 1, 0, 0, 10, 0);
    outSel = 3'd7; idle(3);
    runWindow("R10 code7", 10, 1, 1, 1, 1, 1, 1, 0, 0, 10, 0);
    outSel = 3'd5; idle(3);
    runWindow("R10 code5", 10, 1, 1, 1, 1, 1, 1, 0, 0, 10, 1);
    outSel = 3'd0; idle(3);
    runWindow("R11 leave high", 4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    runWindow("R11 raise", 5, 1, 0, 0, 0, 0, 1, 0, 5, 5, 1);
    outSel = 3'd4; idle(4);
    runWindow("R11 hold high", 4, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    runWindow("R11 finish phase", 1, 1, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    runWindow("R10 after switch", 10, 1, 1, 1, 1, 1, 1, 0, 0, 10, 0);
    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule